// File: doc/BRIEF.md
# Serial Memory Status Register and Write Guard

This unit keeps the eight-bit status byte of a small serial nonvolatile memory and decides whether write commands may go ahead. It holds a write-enable latch, a busy indication, a two-bit block-protect level and a lock bit for the status byte itself. A serial front-end feeds it decoded command strobes. For the page write and status write commands it also reports, at the end of each command (chip select rising), how many whole data bytes were shifted in and whether a partial byte was left over. A separate write sequencer reports its own busy state and a completion pulse. The hardware write-protect pin is sampled directly.

The unit answers three questions. Is a page-write address inside the protected range? May a finished page-write command start? May a finished status-write command start? An accepted status write is self-timed inside the unit. The busy bit stays high for a fixed number of cycles, and then the new protect and lock bits are committed. The protect and lock bits stand in for nonvolatile cells. Only the hard reset clears them. A soft reset clears only the write-enable latch and any status update in flight.

Top module: `sr_protect_unit`

## Requirements
- R1: After hard reset the status byte reads 00h and the page-write start pulse is low.
- R2: A write-enable strobe sets status bit 1 and a write-disable strobe clears it, visible one cycle later. Both strobes are ignored while status bit 0 is 1.
- R3: Status layout: bit 0 busy, bit 1 write enable, bit 2 protect bit 0, bit 3 protect bit 1, bit 7 status lock. Bits 6 to 4 always read 0.
- R4: The address protect output follows the level {bit3,bit2} for a 15-bit address. Level 0 protects nothing, level 1 protects 6000h-7FFFh, level 2 protects 4000h-7FFFh and level 3 protects every address.
- R5: A page-write end is accepted only with write enable set, busy clear, whole bytes and an unprotected address. Acceptance gives a one-cycle start pulse in the next cycle. A rejected command leaves write enable unchanged.
- R6: The sequencer completion pulse clears write enable in the next cycle.
- R7: A status-write end is accepted only with write enable set, busy clear, exactly one whole data byte (byte count 1) and no partial byte. Otherwise nothing changes.
- R8: With the lock bit at 1 and the protect pin low, a status write is ignored and write enable is kept. With the pin high, the lock bit does not block it.
- R9: Only data bits 7, 3 and 2 of a status write are stored. The other data bits have no effect.
- R10: An accepted status write raises busy for SR_UPD_CYCLES cycles starting the next cycle. In the following cycle the new bits show and write enable reads 0.
- R11: A soft reset clears write enable and busy, aborts a pending status update and keeps bits 7, 3 and 2.
- R12: Status bit 0 is 1 whenever the sequencer busy input is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hard power-on reset, synchronous, active high |
| soft_rst | input | 1 | Soft reset, synchronous, active high |
| cmd_wren | input | 1 | Write-enable command strobe |
| cmd_wrdi | input | 1 | Write-disable command strobe |
| sr_wr_end | input | 1 | Status-write command ended (chip select rose) |
| sr_wr_bytes | input | 2 | Whole data bytes in that command, saturating at 2 |
| sr_wr_partial | input | 1 | A partial data byte was left over |
| sr_wr_data | input | 8 | First data byte of the status write |
| pg_wr_end | input | 1 | Page-write command ended |
| pg_wr_ok | input | 1 | Page write carried at least one byte and no partial byte |
| pg_addr | input | 15 | Page-write target address |
| wp_pin | input | 1 | Hardware write-protect pin, low = protect |
| seq_busy | input | 1 | Write sequencer busy |
| seq_done | input | 1 | Write sequencer completion pulse |
| status | output | 8 | Status byte |
| addr_prot | output | 1 | pg_addr lies in the protected range |
| pg_wr_go | output | 1 | Page write accepted, start pulse |

## Verification
The assertions assume the following about the inputs. Every strobe lasts one cycle. A completion pulse from the sequencer arrives only while its busy input is high. A page-write end and a status-write end never fall in the same cycle. The stimulus follows these rules. It drives each strobe in one cycle through its own task and clears it after the next edge. It raises the completion pulse only inside a busy window that it holds itself. It never overlaps the two command ends.

// File: rtl/srpu_pkg.sv
package srpu_pkg;

    typedef struct packed {
        logic       srwp;
        logic [2:0] rsvd;
        logic       bp1;
        logic       bp0;
        logic       wen;
        logic       rdy;
    } stat_t;

    typedef struct packed {
        logic srwp;
        logic bp1;
        logic bp0;
    } nv_t;

    typedef enum logic [1:0] {
        PROT_NONE = 2'b00,
        PROT_QTR  = 2'b01,
        PROT_HALF = 2'b10,
        PROT_ALL  = 2'b11
    } prot_lvl_e;

    localparam logic [1:0] SR_ONE_BYTE = 2'd1;

    // top2 = two most significant address bits
    function automatic logic in_prot(input prot_lvl_e lvl, input logic [1:0] top2);
        case (lvl)
            PROT_NONE: in_prot = 1'b0;
            PROT_QTR:  in_prot = (top2 == 2'b11);
            PROT_HALF: in_prot = top2[1];
            default:   in_prot = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/srpu_permit.sv
module srpu_permit
    import srpu_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  nv_t               nv,
    input  logic              wen,
    input  logic              busy,
    input  logic              wp_pin,
    input  logic [ADDR_W-1:0] pg_addr,
    input  logic              pg_wr_ok,
    input  logic [1:0]        sr_wr_bytes,
    input  logic              sr_wr_partial,
    output logic              addr_prot,
    output logic              pg_allow,
    output logic              sr_allow
);
    localparam int TOP = ADDR_W - 1;

    prot_lvl_e lvl;
    logic      sr_unlocked;
    logic      sr_framed;

    always_comb begin
        lvl         = prot_lvl_e'({nv.bp1, nv.bp0});
        addr_prot   = in_prot(lvl, pg_addr[TOP -: 2]);
        sr_unlocked = wp_pin || !nv.srwp;
        sr_framed   = (sr_wr_bytes == SR_ONE_BYTE) && !sr_wr_partial;
        pg_allow    = wen && !busy && pg_wr_ok && !addr_prot;
        sr_allow    = wen && !busy && sr_framed && sr_unlocked;
    end

    // R8: a locked status byte with the pin low never yields permission
    always_comb begin
        if (nv.srwp && !wp_pin)
            a_r8_lock_blocks: assert (!sr_allow);
    end

endmodule

// File: rtl/srpu_upd_timer.sv
module srpu_upd_timer #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic soft_rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);
    localparam logic [CW-1:0] LAST = CW'(1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || soft_rst)
            cnt <= '0;
        else if (start)
            cnt <= LOAD;
        else if (cnt != '0)
            cnt <= cnt - LAST;
    end

    assign busy = (cnt != '0);
    assign done = (cnt == LAST);

    // R10: a new update never starts on top of a running one
    a_r10_start_idle: assert property (@(posedge clk) disable iff (rst || soft_rst)
        start |-> !busy);

    // R10: a started update is busy in the next cycle
    a_r10_busy_after_start: assert property (@(posedge clk) disable iff (rst || soft_rst)
        start |=> busy);

endmodule

// File: rtl/sr_protect_unit.sv
module sr_protect_unit
    import srpu_pkg::*;
#(
    parameter int ADDR_W        = 15,
    parameter int SR_UPD_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              sr_wr_end,
    input  logic [1:0]        sr_wr_bytes,
    input  logic              sr_wr_partial,
    input  logic [7:0]        sr_wr_data,
    input  logic              pg_wr_end,
    input  logic              pg_wr_ok,
    input  logic [ADDR_W-1:0] pg_addr,
    input  logic              wp_pin,
    input  logic              seq_busy,
    input  logic              seq_done,
    output logic [7:0]        status,
    output logic              addr_prot,
    output logic              pg_wr_go
);
    nv_t   nv_q;
    nv_t   pend_q;
    logic  wen_q;
    logic  upd_busy;
    logic  upd_done;
    logic  rdy;
    logic  pg_allow;
    logic  sr_allow;
    logic  sr_start;
    stat_t stat;

    assign rdy      = seq_busy || upd_busy;
    assign sr_start = sr_wr_end && sr_allow;

    srpu_permit #(.ADDR_W(ADDR_W)) u_permit (
        .nv            (nv_q),
        .wen           (wen_q),
        .busy          (rdy),
        .wp_pin        (wp_pin),
        .pg_addr       (pg_addr),
        .pg_wr_ok      (pg_wr_ok),
        .sr_wr_bytes   (sr_wr_bytes),
        .sr_wr_partial (sr_wr_partial),
        .addr_prot     (addr_prot),
        .pg_allow      (pg_allow),
        .sr_allow      (sr_allow)
    );

    srpu_upd_timer #(.CYCLES(SR_UPD_CYCLES)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .start    (sr_start),
        .busy     (upd_busy),
        .done     (upd_done)
    );

    // write-enable latch: completion clears, then disable, then enable
    always_ff @(posedge clk) begin
        if (rst || soft_rst)
            wen_q <= 1'b0;
        else if (seq_done || upd_done)
            wen_q <= 1'b0;
        else if (!rdy && cmd_wrdi)
            wen_q <= 1'b0;
        else if (!rdy && cmd_wren)
            wen_q <= 1'b1;
    end

    // protect/lock bits: only the hard reset clears them
    always_ff @(posedge clk) begin
        if (rst) begin
            nv_q   <= '0;
            pend_q <= '0;
        end else begin
            if (sr_start)
                pend_q <= '{srwp: sr_wr_data[7], bp1: sr_wr_data[3], bp0: sr_wr_data[2]};
            if (upd_done)
                nv_q <= pend_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst)
            pg_wr_go <= 1'b0;
        else
            pg_wr_go <= pg_wr_end && pg_allow;
    end

    always_comb begin
        stat      = '0;
        stat.rdy  = rdy;
        stat.wen  = wen_q;
        stat.bp0  = nv_q.bp0;
        stat.bp1  = nv_q.bp1;
        stat.srwp = nv_q.srwp;
    end
    assign status = stat;

    // R2: enable strobe while idle sets the latch
    a_r2_wren_sets: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (cmd_wren && !cmd_wrdi && !rdy && !seq_done && !upd_done) |=> status[1]);

    // R2: strobes while busy leave the latch alone
    a_r2_busy_holds: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (rdy && !seq_done && !upd_done) |=> $stable(wen_q));

    // R5: a protected address never starts a page write
    a_r5_prot_rejects: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (pg_wr_end && addr_prot) |=> !pg_wr_go);

    // R6: sequencer completion clears the latch
    a_r6_done_clears: assert property (@(posedge clk) disable iff (rst || soft_rst)
        seq_done |=> !status[1]);

    // R7: a status write with a wrong byte count never starts an update
    a_r7_bad_frame: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (sr_wr_end && (sr_wr_bytes != SR_ONE_BYTE || sr_wr_partial) && !upd_busy) |=> !upd_busy);

    // R10: end of a status update clears the latch
    a_r10_done_clears: assert property (@(posedge clk) disable iff (rst || soft_rst)
        upd_done |=> !status[1]);

    // R11: lock/protect bits change only at the end of an update, soft reset included
    a_r11_nv_hold: assert property (@(posedge clk) disable iff (rst)
        !upd_done |=> $stable(nv_q));

    // R12: sequencer busy always shows in bit 0
    a_r12_busy_flag: assert property (@(posedge clk) disable iff (rst)
        seq_busy |-> status[0]);

endmodule

// File: tb/test_sr_protect_unit.sv
module test_sr_protect_unit;

    localparam int N = 8;

    typedef struct packed {
        logic [1:0]  bp;
        logic [14:0] addr;
        logic        exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 15'h7FFF, 1'b0},
        '{2'd1, 15'h5FFF, 1'b0},
        '{2'd1, 15'h6000, 1'b1},
        '{2'd1, 15'h7FFF, 1'b1},
        '{2'd2, 15'h3FFF, 1'b0},
        '{2'd2, 15'h4000, 1'b1},
        '{2'd3, 15'h0000, 1'b1},
        '{2'd0, 15'h0000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic        cmd_wren = 1'b0;
    logic        cmd_wrdi = 1'b0;
    logic        sr_wr_end = 1'b0;
    logic [1:0]  sr_wr_bytes = 2'd0;
    logic        sr_wr_partial = 1'b0;
    logic [7:0]  sr_wr_data = 8'h00;
    logic        pg_wr_end = 1'b0;
    logic        pg_wr_ok = 1'b0;
    logic [14:0] pg_addr = '0;
    logic        wp_pin = 1'b1;
    logic        seq_busy = 1'b0;
    logic        seq_done = 1'b0;
    logic [7:0]  status;
    logic        addr_prot;
    logic        pg_wr_go;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sr_protect_unit #(.ADDR_W(15), .SR_UPD_CYCLES(N)) i_sr_protect_unit (
        .clk (clk), .rst (rst), .soft_rst (soft_rst),
        .cmd_wren (cmd_wren), .cmd_wrdi (cmd_wrdi),
        .sr_wr_end (sr_wr_end), .sr_wr_bytes (sr_wr_bytes),
        .sr_wr_partial (sr_wr_partial), .sr_wr_data (sr_wr_data),
        .pg_wr_end (pg_wr_end), .pg_wr_ok (pg_wr_ok), .pg_addr (pg_addr),
        .wp_pin (wp_pin), .seq_busy (seq_busy), .seq_done (seq_done),
        .status (status), .addr_prot (addr_prot), .pg_wr_go (pg_wr_go)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string rq);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", rq, act, exp);
        end
    endtask

    task automatic wren();
        cmd_wren = 1'b1; tick(); cmd_wren = 1'b0;
    endtask

    task automatic wrdi();
        cmd_wrdi = 1'b1; tick(); cmd_wrdi = 1'b0;
    endtask

    task automatic sr_write(input logic [7:0] d, input logic [1:0] nb, input logic part);
        sr_wr_data = d; sr_wr_bytes = nb; sr_wr_partial = part; sr_wr_end = 1'b1;
        tick();
        sr_wr_end = 1'b0; sr_wr_bytes = 2'd0; sr_wr_partial = 1'b0;
    endtask

    task automatic pg_write(input logic [14:0] a, input logic ok);
        pg_addr = a; pg_wr_ok = ok; pg_wr_end = 1'b1;
        tick();
        pg_wr_end = 1'b0; pg_wr_ok = 1'b0;
    endtask

    task automatic wait_upd();
        repeat (N) tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2) tick();
        rst = 1'b0;
        chk(status, 8'h00, "R1 status after reset");
        chk({7'd0, pg_wr_go}, 8'h00, "R1 go after reset");

        wren();
        chk(status, 8'h02, "R2 R3 enable sets bit1");
        wrdi();
        chk(status, 8'h00, "R2 disable clears bit1");
        wren();

        // R7: two bytes, then a partial byte, are both ignored
        sr_write(8'h8C, 2'd2, 1'b0);
        chk(status, 8'h02, "R7 two bytes ignored");
        sr_write(8'h8C, 2'd1, 1'b1);
        wait_upd();
        chk(status, 8'h02, "R7 partial byte ignored");

        // R9 R10: accepted write; only bits 7,3,2 land
        sr_write(8'hFF, 2'd1, 1'b0);
        chk(status, 8'h03, "R10 busy right after accept");
        repeat (N - 1) tick();
        chk(status, 8'h03, "R10 busy on last update cycle");
        tick();
        chk(status, 8'h8C, "R9 R10 committed bits, enable cleared");

        // R8: locked with pin low
        wren();
        wp_pin = 1'b0;
        sr_write(8'h00, 2'd1, 1'b0);
        wait_upd();
        chk(status, 8'h8E, "R8 lock with pin low ignores write");
        wp_pin = 1'b1;
        sr_write(8'h00, 2'd1, 1'b0);
        wait_upd();
        chk(status, 8'h00, "R8 pin high overrides lock");

        // R5 R6 R12: page write and sequencer
        wren();
        pg_write(15'h7FFF, 1'b1);
        chk({7'd0, pg_wr_go}, 8'h01, "R5 accepted page write pulses go");
        chk(status, 8'h02, "R5 enable kept until completion");
        tick();
        chk({7'd0, pg_wr_go}, 8'h00, "R5 go is one cycle");
        seq_busy = 1'b1; #1;
        chk(status, 8'h03, "R12 sequencer busy shows in bit0");
        wrdi();
        chk(status, 8'h03, "R2 disable ignored while busy");
        seq_done = 1'b1;
        tick();
        seq_done = 1'b0; seq_busy = 1'b0; #1;
        chk(status, 8'h00, "R6 completion clears enable");

        wren();
        pg_write(15'h0100, 1'b0);
        chk({7'd0, pg_wr_go}, 8'h00, "R5 unaligned page write rejected");
        chk(status, 8'h02, "R5 rejection keeps enable");
        wrdi();
        pg_write(15'h0100, 1'b1);
        chk({7'd0, pg_wr_go}, 8'h00, "R5 no enable rejects");

        // R4: protect-range table
        for (int i = 0; i < 8; i++) begin
            wren();
            sr_write({4'd0, VECS[i].bp, 2'b00}, 2'd1, 1'b0);
            wait_upd();
            pg_addr = VECS[i].addr; #1;
            chk({7'd0, addr_prot}, {7'd0, VECS[i].exp}, "R4 protect range");
        end

        // R5: protected address rejected with enable kept
        wren();
        sr_write(8'h04, 2'd1, 1'b0);
        wait_upd();
        wren();
        pg_write(15'h6000, 1'b1);
        chk({7'd0, pg_wr_go}, 8'h00, "R5 protected address rejected");
        chk(status, 8'h06, "R5 protected rejection keeps enable");

        // R11: soft reset
        sr_write(8'h88, 2'd1, 1'b0);
        wait_upd();
        wren();
        soft_rst = 1'b1; tick(); soft_rst = 1'b0;
        chk(status, 8'h88, "R11 soft reset keeps bits, clears enable");
        wren();
        sr_write(8'h00, 2'd1, 1'b0);
        repeat (2) tick();
        soft_rst = 1'b1; tick(); soft_rst = 1'b0;
        chk(status, 8'h88, "R11 soft reset aborts update");
        wait_upd();
        chk(status, 8'h88, "R11 aborted update never commits");

        rst = 1'b1; tick(); rst = 1'b0;
        chk(status, 8'h00, "R1 hard reset clears all bits");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule